// File: doc/BRIEF.md
# Two-Channel Serial Audio Word Transmitter

This block sends a stream of stereo sample pairs over a three-wire serial audio link made of a bit clock, a channel-select line and a data line. The channel-select line is low during the left word and high during the right word. Every sample leaves most significant bit first, in two's complement. The block works in one of two modes. As clock master, it derives the bit clock and the channel-select line from its own system clock. As clock follower, it takes both lines from outside and times its data from them.

Sample pairs arrive over a valid/ready handshake into a one-pair staging register. The staged pair becomes the active pair at the start of the next left word. If no new pair has arrived by then, the previous pair is sent again.

Each change of the channel-select level, as seen at a rising bit-clock edge, produces a load pulse at the next falling edge. The pulse parallel-loads the shift register from the active left or right word. After that, the register shifts in zeros. This lets a slot longer than the sample carry the sample with a zero tail. Data changes only on falling bit-clock edges, so it is stable when a receiver samples it on the rising edge.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset, and for as long as `en_i` stays low, `sck_o`, `ws_o` and `sd_o` are held at 0 and do not change.
- R2: In master mode, while enabled, `sck_o` has a period of CLK_DIV system clocks, with high and low phases of exactly CLK_DIV/2 clocks each.
- R3: In master mode, `ws_o` starts low. It toggles only in the clock cycle where `sck_o` falls, and each toggle comes exactly SLOT_W falling edges after the previous toggle (or after enable).
- R4: The MSB of a word appears on `sd_o` at the first falling bit-clock edge after the channel-select line changes. A receiver sampling on rising edges therefore collects exactly one slot of bits per word: SLOT_W bits in master mode, or the external slot length in follower mode. The last bit of a word is the one sampled at the rising edge where the new channel-select level is first seen.
- R5: A word sent with channel select low (0) carries the left sample of the active pair, and a word sent with channel select high (1) carries the right sample. The DATA_W sample bits fill the first DATA_W bit positions of the slot, MSB first.
- R6: Every bit after the sample's LSB, up to the end of the slot, is 0.
- R7: `sd_o` changes only in the system clock cycle in which the bit clock falls.
- R8: `smp_ready_o` is high whenever the staging register is empty. A pair is accepted when `smp_valid_i` and `smp_ready_o` are both high. `smp_ready_o` then stays low, and changes on the sample inputs are ignored, until the staged pair is moved to the active pair when the next left word is loaded.
- R9: If no pair is staged when a left word is loaded, the previous left and right samples are sent again.
- R10: In follower mode (`master_i` = 0), `sck_o` and `ws_o` stay at 0. The block synchronises `sck_i` and `ws_i`, samples the channel select on each rising edge of `sck_i`, and frames its words as in R4 to R6 for any slot length of at least DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Starts bit-clock activity and transmission |
| master_i | input | 1 | 1: generate the bit clock and channel select; 0: follow external ones |
| sck_i | input | 1 | External bit clock (follower mode) |
| ws_i | input | 1 | External channel select (follower mode) |
| smp_valid_i | input | 1 | A sample pair is offered |
| smp_ready_o | output | 1 | The staging register can take a pair |
| smp_left_i | input | DATA_W | Left sample, two's complement |
| smp_right_i | input | DATA_W | Right sample, two's complement |
| sck_o | output | 1 | Generated bit clock (master mode) |
| ws_o | output | 1 | Generated channel select (master mode) |
| sd_o | output | 1 | Serial data |

## Verification
The assertions assume that `master_i` changes only while reset is asserted. They also assume that, in follower mode, the external bit clock stays high and stays low for several system clocks, and that `ws_i` changes only while `sck_i` is low. The bench drives the follower-mode lines on system-clock falling edges with six-clock half periods and toggles `ws_i` only together with a falling `sck_i`. It switches mode only inside a reset pulse. It offers new pairs only while a right word is in flight, well away from a left load, so that the pair each frame should carry is known exactly.

// File: rtl/sat_pkg.sv
package sat_pkg;
  // channel carried by the current word, as encoded on the select line
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // one-cycle bit-clock edge strobes in the system clock domain
  typedef struct packed {
    logic rise;
    logic fall;
  } bclk_ev_t;
endpackage

// File: rtl/sat_master_clk.sv
module sat_master_clk
  import sat_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int SLOT_W  = 32
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  output logic     sck_o,
  output logic     ws_o,
  output bclk_ev_t ev_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;

  logic [CW-1:0] div_q, div_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          sck_q, sck_d;
  logic          ws_q, ws_d;
  logic          tick;

  assign tick = en_i && (div_q == CW'(HALF - 1));

  always_comb begin
    div_d     = div_q;
    sck_d     = sck_q;
    bit_d     = bit_q;
    ws_d      = ws_q;
    ev_o.rise = tick & ~sck_q;
    ev_o.fall = tick & sck_q;
    if (en_i) begin
      div_d = tick ? '0 : div_q + CW'(1);
    end
    if (tick) begin
      sck_d = ~sck_q;
    end
    if (ev_o.fall) begin
      if (bit_q == BW'(SLOT_W - 1)) begin
        bit_d = '0;
        ws_d  = ~ws_q;
      end else begin
        bit_d = bit_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      bit_q <= '0;
      sck_q <= 1'b0;
      ws_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      bit_q <= bit_d;
      sck_q <= sck_d;
      ws_q  <= ws_d;
    end
  end

  assign sck_o = sck_q;
  assign ws_o  = ws_q;

  // R3: select only moves together with a falling bit clock
  p_ws_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_q != $past(ws_q)) |-> ($past(sck_q) && !sck_q));
endmodule

// File: rtl/sat_follow_sync.sv
module sat_follow_sync
  import sat_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     sck_i,
  input  logic     ws_i,
  output logic     ws_o,
  output bclk_ev_t ev_o
);
  // one extra stage on the clock path gives the edge detector its history
  logic [SYNC_N:0]   sck_pipe_q, sck_pipe_d;
  logic [SYNC_N-1:0] ws_pipe_q, ws_pipe_d;

  always_comb begin
    sck_pipe_d[0] = sck_i;
    ws_pipe_d[0]  = ws_i;
  end

  for (genvar i = 1; i <= SYNC_N; i++) begin : g_sck_stage
    assign sck_pipe_d[i] = sck_pipe_q[i-1];
  end
  for (genvar i = 1; i < SYNC_N; i++) begin : g_ws_stage
    assign ws_pipe_d[i] = ws_pipe_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_pipe_q <= '0;
      ws_pipe_q  <= '0;
    end else begin
      sck_pipe_q <= sck_pipe_d;
      ws_pipe_q  <= ws_pipe_d;
    end
  end

  assign ws_o      = ws_pipe_q[SYNC_N-1];
  assign ev_o.rise = en_i &  sck_pipe_q[SYNC_N-1] & ~sck_pipe_q[SYNC_N];
  assign ev_o.fall = en_i & ~sck_pipe_q[SYNC_N-1] &  sck_pipe_q[SYNC_N];
endmodule

// File: rtl/sat_word_tx.sv
module sat_word_tx
  import sat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bclk_ev_t          ev_i,
  input  logic              ws_line_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [DATA_W-1:0] smp_left_i,
  input  logic [DATA_W-1:0] smp_right_i,
  output logic              sd_o
);
  localparam int TMAX = DATA_W + 1;
  localparam int TW   = $clog2(DATA_W + 2);

  chan_e             ws_smp_q, ws_smp_d, ws_prev_q, ws_prev_d;
  logic [DATA_W-1:0] stg_l_q, stg_l_d, stg_r_q, stg_r_d;
  logic [DATA_W-1:0] act_l_q, act_l_d, act_r_q, act_r_d;
  logic [DATA_W-1:0] shr_q, shr_d, load_word;
  logic              stg_full_q, stg_full_d;
  logic              load_pulse, accept, take;

  assign accept      = smp_valid_i & ~stg_full_q;
  assign load_pulse  = ev_i.fall & (ws_smp_q != ws_prev_q);
  assign take        = load_pulse & (ws_smp_q == CH_LEFT) & stg_full_q;
  assign smp_ready_o = ~stg_full_q;

  always_comb begin
    load_word = act_r_q;
    if (ws_smp_q == CH_LEFT) begin
      load_word = stg_full_q ? stg_l_q : act_l_q;
    end
  end

  always_comb begin
    ws_smp_d   = ws_smp_q;
    ws_prev_d  = ws_prev_q;
    stg_l_d    = stg_l_q;
    stg_r_d    = stg_r_q;
    act_l_d    = act_l_q;
    act_r_d    = act_r_q;
    stg_full_d = stg_full_q;
    shr_d      = shr_q;
    if (ev_i.rise) begin
      ws_prev_d = ws_smp_q;
      ws_smp_d  = chan_e'(ws_line_i);
    end
    if (accept) begin
      stg_l_d    = smp_left_i;
      stg_r_d    = smp_right_i;
      stg_full_d = 1'b1;
    end
    if (take) begin
      act_l_d    = stg_l_q;
      act_r_d    = stg_r_q;
      stg_full_d = 1'b0;
    end
    if (ev_i.fall) begin
      shr_d = load_pulse ? load_word : {shr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_smp_q   <= CH_RIGHT;
      ws_prev_q  <= CH_RIGHT;
      stg_l_q    <= '0;
      stg_r_q    <= '0;
      act_l_q    <= '0;
      act_r_q    <= '0;
      stg_full_q <= 1'b0;
      shr_q      <= '0;
    end else begin
      ws_smp_q   <= ws_smp_d;
      ws_prev_q  <= ws_prev_d;
      stg_l_q    <= stg_l_d;
      stg_r_q    <= stg_r_d;
      act_l_q    <= act_l_d;
      act_r_q    <= act_r_d;
      stg_full_q <= stg_full_d;
      shr_q      <= shr_d;
    end
  end

  assign sd_o = shr_q[DATA_W-1];

  // bits presented since the last load, saturating; guards the zero tail
  logic [TW-1:0] tail_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= TW'(TMAX);
    end else if (ev_i.fall) begin
      if (load_pulse) tail_q <= TW'(1);
      else if (tail_q != TW'(TMAX)) tail_q <= tail_q + TW'(1);
    end
  end

  // R6: nothing but zeros once the LSB has been presented
  p_zero_tail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_q == TW'(TMAX)) |-> !sd_o);
  // R7: data holds between falling bit-clock edges
  p_sd_on_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i.fall |=> $stable(sd_o));
  // R8: an accepted pair closes the handshake until it is consumed
  p_ready_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_ready_o) |=> !smp_ready_o);
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SLOT_W  = 32,
  parameter int CLK_DIV = 8,
  parameter int SYNC_N  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [DATA_W-1:0] smp_left_i,
  input  logic [DATA_W-1:0] smp_right_i,
  output logic              sck_o,
  output logic              ws_o,
  output logic              sd_o
);
  bclk_ev_t m_ev, f_ev, ev;
  logic     m_sck, m_ws, f_ws, ws_line;

  sat_master_clk #(.CLK_DIV(CLK_DIV), .SLOT_W(SLOT_W)) u_mclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i & master_i),
    .sck_o (m_sck),
    .ws_o  (m_ws),
    .ev_o  (m_ev)
  );

  sat_follow_sync #(.SYNC_N(SYNC_N)) u_fsync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i & ~master_i),
    .sck_i (sck_i),
    .ws_i  (ws_i),
    .ws_o  (f_ws),
    .ev_o  (f_ev)
  );

  assign ev      = master_i ? m_ev : f_ev;
  assign ws_line = master_i ? m_ws : f_ws;

  sat_word_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .ws_line_i  (ws_line),
    .smp_valid_i(smp_valid_i),
    .smp_ready_o(smp_ready_o),
    .smp_left_i (smp_left_i),
    .smp_right_i(smp_right_i),
    .sd_o       (sd_o)
  );

  assign sck_o = master_i & m_sck;
  assign ws_o  = master_i & m_ws;

  // R1: the link lines are frozen while disabled
  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(sd_o) && $stable(ws_o) && $stable(sck_o)));
endmodule

// File: tb/serial_audio_tx_tb.sv
module serial_audio_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 6;
  localparam int SW   = 8;
  localparam int DIV  = 4;
  localparam int FSLOT = 10;  // slot length used in follower mode
  localparam int FHALF = 6;   // follower bit-clock half period, system clocks

  logic clk, rst_n, en, master_tb, sck_i, ws_i, valid, ready;
  logic [DW-1:0] left, right;
  logic sck_o, ws_o, sd_o;

  int checks = 0;
  int errors = 0;
  int words_checked = 0;

  serial_audio_tx #(.DATA_W(DW), .SLOT_W(SW), .CLK_DIV(DIV), .SYNC_N(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .master_i(master_tb),
    .sck_i(sck_i), .ws_i(ws_i), .smp_valid_i(valid), .smp_ready_o(ready),
    .smp_left_i(left), .smp_right_i(right),
    .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] samp_l(input int k);
    case (k % 8)
      0: samp_l = 6'h20;
      1: samp_l = 6'h1F;
      2: samp_l = 6'h00;
      3: samp_l = 6'h3F;
      default: samp_l = DW'((k * 13 + 7) % 64);
    endcase
  endfunction

  function automatic logic [DW-1:0] samp_r(input int k);
    samp_r = (samp_l(k) ^ 6'h15) + DW'(k);
  endfunction

  // bench model of the staged and active pair
  logic [DW-1:0] cur_l, cur_r, pend_l, pend_r;
  logic pend_v;
  int   slot_len;

  // receiver: samples on rising bit clock, like any listener on the link
  logic        rx_on, rprev, rstarted, wsb;
  logic [31:0] rbuf;
  int          rcnt;
  string       vtag;
  event        right_start;
  logic        rx_sck;
  assign rx_sck = master_tb ? sck_o : sck_i;

  always @(posedge rx_sck) begin
    if (rx_on) begin
      wsb  = master_tb ? ws_o : ws_i;
      rbuf = (rbuf << 1) | {31'd0, sd_o};
      rcnt++;
      if (wsb != rprev) begin
        if (rstarted) begin
          logic [DW-1:0] exp_s;
          logic [31:0]   tail_mask;
          exp_s     = rprev ? cur_r : cur_l;
          tail_mask = (32'd1 << (slot_len - DW)) - 32'd1;
          vtag      = master_tb ? "R5,R9" : "R10";
          chk(rcnt == slot_len, "R4 slot length", rcnt, slot_len);
          chk((rbuf >> (slot_len - DW)) == {26'd0, exp_s}, vtag,
              rbuf >> (slot_len - DW), exp_s);
          chk((rbuf & tail_mask) == 32'd0, "R6 zero tail", rbuf & tail_mask, 0);
          words_checked++;
        end
        rstarted = 1'b1;
        if (wsb == 1'b0) begin
          if (pend_v) begin
            cur_l  = pend_l;
            cur_r  = pend_r;
            pend_v = 1'b0;
          end
        end else begin
          ->right_start;
        end
        rbuf = 32'd0;
        rcnt = 0;
      end
      rprev = wsb;
    end
  end

  // line monitor at the quiet clock edge
  logic mon_m, mon_f, m_psck, m_pws, m_psd, m_runv;
  int   m_run, m_falls;
  always @(negedge clk) begin
    if (mon_m) begin
      if (m_psck && !sck_o) m_falls++;
      if (sck_o != m_psck) begin
        if (m_runv) chk(m_run == DIV / 2, "R2 phase length", m_run, DIV / 2);
        m_runv = 1'b1;
        m_run  = 1;
      end else begin
        m_run++;
      end
      if (ws_o != m_pws) begin
        chk(m_psck && !sck_o, "R3 toggle on fall", sck_o, 0);
        chk(m_falls == SW, "R3 falls per slot", m_falls, SW);
        m_falls = 0;
      end
      if (sd_o != m_psd) chk(m_psck && !sck_o, "R7 data on fall", sck_o, 0);
      m_psck = sck_o;
      m_pws  = ws_o;
      m_psd  = sd_o;
    end
    if (mon_f && (sck_i != m_psck)) begin
      chk(!sck_o && !ws_o, "R10 outputs quiet", {sck_o, ws_o}, 0);
      m_psck = sck_i;
    end
  end

  task automatic offer(input int k);
    @(negedge clk);
    chk(ready == 1'b1, "R8 ready when empty", ready, 1);
    valid = 1'b1;
    left  = samp_l(k);
    right = samp_r(k);
    @(negedge clk);
    pend_l = samp_l(k);
    pend_r = samp_r(k);
    pend_v = 1'b1;
    chk(ready == 1'b0, "R8 ready after accept", ready, 0);
    left  = ~left;   // must be ignored while the stage is full
    right = ~right;
    repeat (3) begin
      @(negedge clk);
      chk(ready == 1'b0, "R8 ready held low", ready, 0);
    end
    valid = 1'b0;
  endtask

  logic slv_run;
  task automatic follower_gen();
    int falls = 0;
    while (slv_run) begin
      repeat (FHALF) @(negedge clk);
      sck_i = 1'b1;
      repeat (FHALF) @(negedge clk);
      sck_i = 1'b0;
      falls++;
      if (falls == FSLOT) begin
        ws_i  = ~ws_i;
        falls = 0;
      end
    end
  endtask

  task automatic rx_reset();
    rx_on = 1'b0; rprev = 1'b1; rstarted = 1'b0; rbuf = 32'd0; rcnt = 0;
    cur_l = '0; cur_r = '0; pend_v = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k = 0;
    rst_n = 1'b0; en = 1'b0; master_tb = 1'b1; sck_i = 1'b0; ws_i = 1'b0;
    valid = 1'b0; left = '0; right = '0; slv_run = 1'b0;
    mon_m = 1'b0; mon_f = 1'b0; m_psck = 1'b0; m_pws = 1'b0; m_psd = 1'b0;
    m_runv = 1'b0; m_run = 0; m_falls = 0;
    rx_reset();
    slot_len = SW;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mon_m = 1'b1;
    repeat (20) @(negedge clk);
    // R1: quiet after reset while disabled
    chk(sck_o == 1'b0, "R1 sck idle", sck_o, 0);
    chk(ws_o == 1'b0, "R1 ws idle", ws_o, 0);
    chk(sd_o == 1'b0, "R1 data idle", sd_o, 0);
    offer(k++);
    repeat (10) @(negedge clk);
    chk(sck_o == 1'b0 && sd_o == 1'b0, "R1 idle with staged pair", {sck_o, sd_o}, 0);
    rx_on = 1'b1;
    en = 1'b1;
    for (int f = 1; f <= 12; f++) begin
      @(right_start);
      if (f % 3 != 0) offer(k++);  // every third frame offers nothing: R9 repeat
    end
    @(right_start);
    @(right_start);

    // follower mode, longer slot than the sample
    @(negedge clk);
    en = 1'b0; mon_m = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    rx_reset();
    master_tb = 1'b0; slot_len = FSLOT; sck_i = 1'b0; ws_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    m_psck = 1'b0;
    mon_f = 1'b1;
    offer(k++);
    rx_on = 1'b1;
    en = 1'b1;
    slv_run = 1'b1;
    fork
      follower_gen();
    join_none
    for (int f = 1; f <= 6; f++) begin
      @(right_start);
      if (f % 3 != 0) offer(k++);
    end
    @(right_start);
    @(right_start);
    slv_run = 1'b0;
    rx_on = 1'b0;
    mon_f = 1'b0;
    chk(words_checked >= 30, "R4 words observed", words_checked, 30);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule